// File: doc/BRIEF.md
# Split Instruction/Data Address Translation Unit

This block turns a virtual address into a physical address. It has two small direct-mapped translation buffers. An instruction fetch looks only in the instruction buffer. A load or a store looks only in the data buffer. Each buffer entry is a pair of words. The tag word holds the full virtual page number and, in bit 0, a valid flag. The frame word holds the physical page frame and six permission bits. The current privilege level decides which three of those six bits apply.

A request is captured on a clock edge. The lookup is combinational from that captured copy, and the result appears with a strobe one cycle later. The result has four parts:
- the physical address;
- the rights granted;
- a status: hit, no tag match, entry invalid, or permission denied;
- an exception class.

When a result carries an exception, the faulting virtual address is stored in a holding register at the next edge. When translation is switched off, the address passes through unchanged and every right is granted.

Software fills the entries through a write port. The port picks the buffer, the entry and the word. Page refill from memory tables is left to the surrounding logic.

Top module: `dm_xlate_unit`

## Requirements
- R1: Reset clears every tag and frame word in both buffers and drives `rsp_valid` and `fault_vaddr` to 0. After reset, an enabled lookup whose virtual page number is 0 reports status invalid. Any other page reports no match.
- R2: `rsp_valid` is 1 in exactly the cycle after a cycle in which `req_valid` was 1. The address, rights, status and fault outputs are valid in that same cycle.
- R3: The entry index is the low log2(entries) bits of the virtual page number (address bits above PAGE_BITS). A hit needs tag-word bits [ADDR_W-1:PAGE_BITS] to equal the whole virtual page number. Two pages that share an index but differ above it report no match (status 1).
- R4: Tag-word bit 0 is the valid flag. If the tag matches but bit 0 is 0, the status is invalid (2), which is different from no match (1).
- R5: Frame-word permission bits are: supervisor read 1, supervisor write 2, supervisor execute 3, user read 4, user write 5, user execute 6. With `req_super`=1 the supervisor bits apply; otherwise the user bits apply.
- R6: `req_kind` encoding is 0 load, 1 store, 2 fetch, 3 treated as a load. A fetch uses only the instruction buffer and needs execute. A load uses the data buffer and needs read. A store uses the data buffer and needs write. A missing right gives status denied (3).
- R7: On a hit (status 0), `rsp_paddr` is the frame-word bits [ADDR_W-1:PAGE_BITS] joined with the virtual address bits [PAGE_BITS-1:0]. `rsp_rights` is {execute,write,read}: a fetch reports {x,0,0} and a data access reports {0,w,r}. On any fault, `rsp_paddr` and `rsp_rights` are 0.
- R8: `rsp_fault` encoding is 0 none, 1 instruction miss, 2 data miss, 3 instruction page fault, 4 data page fault. No match and invalid give a miss class. Denied gives a page-fault class. The fetch/data choice follows the access kind.
- R9: At the edge after a response with a nonzero `rsp_fault`, `fault_vaddr` takes that request's virtual address. It holds its value across responses without a fault.
- R10: When `mmu_on` is captured as 0, `rsp_paddr` equals the virtual address, `rsp_rights` is 3'b111, the status is hit and the fault is 0, whatever the buffers contain.
- R11: A write with `wr_en`=1 loads `wr_value` at the clock edge into the buffer picked by `wr_dtlb` (0 instruction, 1 data). The entry is picked by `wr_index` and the word by `wr_xlate` (0 tag word, 1 frame word). The other buffer is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_vaddr | input | ADDR_W | Virtual address |
| req_kind | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 load |
| req_super | input | 1 | Supervisor privilege |
| mmu_on | input | 1 | Translation enable |
| wr_en | input | 1 | Entry write strobe |
| wr_dtlb | input | 1 | Write target: 0 instruction buffer, 1 data buffer |
| wr_xlate | input | 1 | Word select: 0 tag word, 1 frame word |
| wr_index | input | WIDX_W | Entry number to write |
| wr_value | input | ADDR_W | Word to write |
| rsp_valid | output | 1 | Result strobe, one cycle after the request |
| rsp_paddr | output | ADDR_W | Physical address |
| rsp_rights | output | 3 | Granted rights {x,w,r} |
| rsp_status | output | 2 | 0 hit, 1 no match, 2 invalid, 3 denied |
| rsp_fault | output | 3 | Exception class |
| fault_vaddr | output | ADDR_W | Last faulting virtual address |

## Verification
Directed lookups separate the four outcomes on a single entry. A matching page tells a valid entry from an invalid one. A page that shares the index but differs above it tells a full-page comparison from an index-only comparison. The same page is tried as a fetch, a load and a store, at both privilege levels, against a frame word with mixed permissions. This shows that the right bits are chosen and that the two buffers are kept apart. A randomised stream then interleaves entry writes with lookups from a narrow page pool. The pool makes aliases, stale entries and valid-bit changes frequent, and every response and the held fault address are compared against a bench model.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;
   typedef enum logic [1:0] {
      KIND_LOAD  = 2'd0,
      KIND_STORE = 2'd1,
      KIND_FETCH = 2'd2,
      KIND_RSVD  = 2'd3
   } acc_kind_e;

   typedef enum logic [1:0] {
      ST_HIT     = 2'd0,
      ST_NOMATCH = 2'd1,
      ST_INVALID = 2'd2,
      ST_DENIED  = 2'd3
   } xl_status_e;

   typedef enum logic [2:0] {
      FLT_NONE  = 3'd0,
      FLT_IMISS = 3'd1,
      FLT_DMISS = 3'd2,
      FLT_IPAGE = 3'd3,
      FLT_DPAGE = 3'd4
   } xl_fault_e;

   // permission bit positions inside the frame word
   localparam int unsigned PB_SUP_R = 1;
   localparam int unsigned PB_SUP_W = 2;
   localparam int unsigned PB_SUP_X = 3;
   localparam int unsigned PB_USR_R = 4;
   localparam int unsigned PB_USR_W = 5;
   localparam int unsigned PB_USR_X = 6;
   localparam int unsigned PB_TOP   = 6;
endpackage

// File: rtl/xlate_bank.sv
module xlate_bank #(
   parameter int unsigned SETS   = 64,
   parameter int unsigned ADDR_W = 32,
   localparam int unsigned IW    = $clog2(SETS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_xlate,
   input  logic [IW-1:0]     wr_idx,
   input  logic [ADDR_W-1:0] wr_value,
   input  logic [IW-1:0]     rd_idx,
   output logic [ADDR_W-1:0] rd_match,
   output logic [ADDR_W-1:0] rd_frame
);
   logic [ADDR_W-1:0] match_q [SETS];
   logic [ADDR_W-1:0] frame_q [SETS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(SETS); i++) begin
            match_q[i] <= '0;
            frame_q[i] <= '0;
         end
      end else if (wr_en) begin
         if (wr_xlate) frame_q[wr_idx] <= wr_value;
         else          match_q[wr_idx] <= wr_value;
      end
   end

   assign rd_match = match_q[rd_idx];
   assign rd_frame = frame_q[rd_idx];
endmodule

// File: rtl/xlate_judge.sv
module xlate_judge
   import tlbx_pkg::*;
#(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned PAGE_BITS = 13
) (
   input  logic [ADDR_W-1:0] vaddr,
   input  acc_kind_e         kind,
   input  logic              sup,
   input  logic              enable,
   input  logic [ADDR_W-1:0] match_w,
   input  logic [ADDR_W-1:0] frame_w,
   output logic [ADDR_W-1:0] paddr,
   output logic [2:0]        rights,
   output xl_status_e        status,
   output xl_fault_e         fault
);
   logic is_fetch, is_store, can_r, can_w, can_x, tag_eq, granted;
   logic unused_bits;

   assign is_fetch = (kind == KIND_FETCH);
   assign is_store = (kind == KIND_STORE);
   assign can_r    = sup ? frame_w[PB_SUP_R] : frame_w[PB_USR_R];
   assign can_w    = sup ? frame_w[PB_SUP_W] : frame_w[PB_USR_W];
   assign can_x    = sup ? frame_w[PB_SUP_X] : frame_w[PB_USR_X];
   assign tag_eq   = (match_w[ADDR_W-1:PAGE_BITS] == vaddr[ADDR_W-1:PAGE_BITS]);
   assign granted  = is_fetch ? can_x : (is_store ? can_w : can_r);
   assign unused_bits = ^{match_w[PAGE_BITS-1:1], frame_w[PAGE_BITS-1:PB_TOP+1], frame_w[0]};

   always_comb begin
      paddr  = '0;
      rights = 3'b000;
      status = ST_HIT;
      fault  = FLT_NONE;
      if (!enable) begin
         paddr  = vaddr;
         rights = 3'b111;
      end else if (!tag_eq) begin
         status = ST_NOMATCH;
         fault  = is_fetch ? FLT_IMISS : FLT_DMISS;
      end else if (!match_w[0]) begin
         status = ST_INVALID;
         fault  = is_fetch ? FLT_IMISS : FLT_DMISS;
      end else if (!granted) begin
         status = ST_DENIED;
         fault  = is_fetch ? FLT_IPAGE : FLT_DPAGE;
      end else begin
         paddr  = {frame_w[ADDR_W-1:PAGE_BITS], vaddr[PAGE_BITS-1:0]};
         rights = is_fetch ? {can_x, 2'b00} : {1'b0, can_w, can_r};
      end
   end
endmodule

// File: rtl/dm_xlate_unit.sv
module dm_xlate_unit
   import tlbx_pkg::*;
#(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned PAGE_BITS = 13,
   parameter int unsigned ISETS     = 64,
   parameter int unsigned DSETS     = 64,
   localparam int unsigned IIW      = $clog2(ISETS),
   localparam int unsigned DIW      = $clog2(DSETS),
   localparam int unsigned WIDX_W   = (IIW > DIW) ? IIW : DIW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_vaddr,
   input  logic [1:0]        req_kind,
   input  logic              req_super,
   input  logic              mmu_on,
   input  logic              wr_en,
   input  logic              wr_dtlb,
   input  logic              wr_xlate,
   input  logic [WIDX_W-1:0] wr_index,
   input  logic [ADDR_W-1:0] wr_value,
   output logic              rsp_valid,
   output logic [ADDR_W-1:0] rsp_paddr,
   output logic [2:0]        rsp_rights,
   output logic [1:0]        rsp_status,
   output logic [2:0]        rsp_fault,
   output logic [ADDR_W-1:0] fault_vaddr
);
   // elaboration-time parameter checks
   if (ISETS < 2 || (ISETS & (ISETS - 1)) != 0) begin : g_bad_isets
      $error("ISETS must be a power of two, at least 2");
   end
   if (DSETS < 2 || (DSETS & (DSETS - 1)) != 0) begin : g_bad_dsets
      $error("DSETS must be a power of two, at least 2");
   end
   if (PAGE_BITS <= PB_TOP || PAGE_BITS >= ADDR_W) begin : g_bad_page
      $error("PAGE_BITS must leave room for permission bits and a page number");
   end
   if (WIDX_W > ADDR_W - PAGE_BITS) begin : g_bad_idx
      $error("index wider than the virtual page number");
   end

   logic              v_q, sup_q, en_q;
   logic [ADDR_W-1:0] va_q, far_q;
   acc_kind_e         kind_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_q    <= 1'b0;
         va_q   <= '0;
         kind_q <= KIND_LOAD;
         sup_q  <= 1'b0;
         en_q   <= 1'b0;
      end else begin
         v_q <= req_valid;
         if (req_valid) begin
            va_q   <= req_vaddr;
            kind_q <= acc_kind_e'(req_kind);
            sup_q  <= req_super;
            en_q   <= mmu_on;
         end
      end
   end

   logic [ADDR_W-1:0] im_w, if_w, dm_w, df_w;

   xlate_bank #(.SETS(ISETS), .ADDR_W(ADDR_W)) u_ibank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en && !wr_dtlb),
      .wr_xlate (wr_xlate),
      .wr_idx   (wr_index[IIW-1:0]),
      .wr_value (wr_value),
      .rd_idx   (va_q[PAGE_BITS +: IIW]),
      .rd_match (im_w),
      .rd_frame (if_w)
   );

   xlate_bank #(.SETS(DSETS), .ADDR_W(ADDR_W)) u_dbank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en && wr_dtlb),
      .wr_xlate (wr_xlate),
      .wr_idx   (wr_index[DIW-1:0]),
      .wr_value (wr_value),
      .rd_idx   (va_q[PAGE_BITS +: DIW]),
      .rd_match (dm_w),
      .rd_frame (df_w)
   );

   logic              use_i;
   logic [ADDR_W-1:0] sel_match, sel_frame;
   xl_status_e        status_w;
   xl_fault_e         fault_w;

   assign use_i     = (kind_q == KIND_FETCH);
   assign sel_match = use_i ? im_w : dm_w;
   assign sel_frame = use_i ? if_w : df_w;

   xlate_judge #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_judge (
      .vaddr   (va_q),
      .kind    (kind_q),
      .sup     (sup_q),
      .enable  (en_q),
      .match_w (sel_match),
      .frame_w (sel_frame),
      .paddr   (rsp_paddr),
      .rights  (rsp_rights),
      .status  (status_w),
      .fault   (fault_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          far_q <= '0;
      else if (v_q && fault_w != FLT_NONE) far_q <= va_q;
   end

   assign rsp_valid   = v_q;
   assign rsp_status  = status_w;
   assign rsp_fault   = fault_w;
   assign fault_vaddr = far_q;

   // response strobe follows the request by one cycle
   assert_rsp_timing_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   assert_bypass_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !$past(mmu_on) |-> rsp_paddr == $past(req_vaddr) && rsp_rights == 3'b111
                                      && rsp_fault == 3'd0);

   assert_offset_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_status == 2'd0 |-> rsp_paddr[PAGE_BITS-1:0] == $past(req_vaddr[PAGE_BITS-1:0]));

   assert_fault_clears_out_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_fault != 3'd0 |-> rsp_rights == 3'b000 && rsp_paddr == '0);

   assert_miss_class_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && (rsp_status == 2'd1 || rsp_status == 2'd2) |-> rsp_fault == 3'd1 || rsp_fault == 3'd2);

   assert_fetch_class_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_fault != 3'd0 && $past(req_kind) == 2'd2 |-> rsp_fault == 3'd1 || rsp_fault == 3'd3);

   assert_fault_latch_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_fault != 3'd0 |=> fault_vaddr == $past(req_vaddr, 2));

   assert_fault_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(rsp_valid && rsp_fault != 3'd0) |=> $stable(fault_vaddr));
endmodule

// File: tb/dm_xlate_unit_tb_top.sv
module dm_xlate_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_vaddr = '0;
   logic [1:0]  req_kind = '0;
   logic        req_super = 1'b0;
   logic        mmu_on = 1'b1;
   logic        wr_en = 1'b0;
   logic        wr_dtlb = 1'b0;
   logic        wr_xlate = 1'b0;
   logic [5:0]  wr_index = '0;
   logic [31:0] wr_value = '0;
   logic        rsp_valid;
   logic [31:0] rsp_paddr;
   logic [2:0]  rsp_rights;
   logic [1:0]  rsp_status;
   logic [2:0]  rsp_fault;
   logic [31:0] fault_vaddr;

   dm_xlate_unit dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
      .req_kind(req_kind), .req_super(req_super), .mmu_on(mmu_on),
      .wr_en(wr_en), .wr_dtlb(wr_dtlb), .wr_xlate(wr_xlate),
      .wr_index(wr_index), .wr_value(wr_value), .rsp_valid(rsp_valid),
      .rsp_paddr(rsp_paddr), .rsp_rights(rsp_rights), .rsp_status(rsp_status),
      .rsp_fault(rsp_fault), .fault_vaddr(fault_vaddr)
   );

   always #5 clk = ~clk;

   int nchk = 0;
   int nerr = 0;
   bit done = 1'b0;
   logic [31:0] im [64];
   logic [31:0] ifr[64];
   logic [31:0] dm [64];
   logic [31:0] dfr[64];
   logic [31:0] exp_far = '0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic tlb_wr(input bit d, input bit xl, input int idx, input logic [31:0] v);
      @(negedge clk);
      wr_en = 1'b1; wr_dtlb = d; wr_xlate = xl; wr_index = 6'(idx); wr_value = v;
      if (d) begin if (xl) dfr[idx] = v; else dm[idx] = v; end
      else   begin if (xl) ifr[idx] = v; else im[idx] = v; end
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic predict(input logic [31:0] va, input logic [1:0] k, input bit sup, input bit en,
                          output logic [31:0] pa, output logic [2:0] rt,
                          output logic [1:0] st, output logic [2:0] fc);
      logic [31:0] m, t;
      bit f, r, w, x, ok;
      int idx;
      f = (k == 2'd2);
      idx = int'(va[18:13]);
      m = f ? im[idx] : dm[idx];
      t = f ? ifr[idx] : dfr[idx];
      r = sup ? t[1] : t[4];
      w = sup ? t[2] : t[5];
      x = sup ? t[3] : t[6];
      ok = f ? x : ((k == 2'd1) ? w : r);
      pa = '0; rt = '0; st = 2'd0; fc = 3'd0;
      if (!en) begin
         pa = va; rt = 3'b111;
      end else if (m[31:13] != va[31:13]) begin
         st = 2'd1; fc = f ? 3'd1 : 3'd2;
      end else if (!m[0]) begin
         st = 2'd2; fc = f ? 3'd1 : 3'd2;
      end else if (!ok) begin
         st = 2'd3; fc = f ? 3'd3 : 3'd4;
      end else begin
         pa = {t[31:13], va[12:0]};
         rt = f ? {x, 2'b00} : {1'b0, w, r};
      end
   endtask

   task automatic do_req(input logic [31:0] va, input logic [1:0] k, input bit sup,
                         input bit en, input string tag);
      logic [31:0] pa; logic [2:0] rt; logic [1:0] st; logic [2:0] fc;
      predict(va, k, sup, en, pa, rt, st, fc);
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = va; req_kind = k; req_super = sup; mmu_on = en;
      @(negedge clk);
      req_valid = 1'b0;
      chk({tag, " R2 valid"}, 32'(rsp_valid), 32'd1);
      chk({tag, " paddr"},  rsp_paddr, pa);
      chk({tag, " rights"}, 32'(rsp_rights), 32'(rt));
      chk({tag, " status"}, 32'(rsp_status), 32'(st));
      chk({tag, " R8 fault"}, 32'(rsp_fault), 32'(fc));
      if (fc != 3'd0) exp_far = va;
      @(negedge clk);
      chk({tag, " R9 fault_vaddr"}, fault_vaddr, exp_far);
      chk({tag, " R2 strobe drop"}, 32'(rsp_valid), 32'd0);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         nerr++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", nchk, nerr);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      for (int i = 0; i < 64; i++) begin
         im[i] = '0; ifr[i] = '0; dm[i] = '0; dfr[i] = '0;
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      chk("R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
      chk("R1 fault_vaddr after reset", fault_vaddr, 32'd0);
      do_req(32'h0000_0123, 2'd0, 1'b1, 1'b1, "R1 page0 invalid");
      do_req(32'h0040_2000, 2'd2, 1'b1, 1'b1, "R1 other page nomatch");

      // R11 R3 R5 R7: data entry 5, vpn 5
      tlb_wr(1'b1, 1'b0, 5, (32'd5 << 13) | 32'd1);
      tlb_wr(1'b1, 1'b1, 5, 32'h1234_6000 | 32'h16);
      do_req(32'h0000_A5A5, 2'd0, 1'b0, 1'b1, "R5 user load hit");
      do_req(32'h0000_A004, 2'd1, 1'b0, 1'b1, "R6 user store denied");
      do_req(32'h0000_BFFF, 2'd1, 1'b1, 1'b1, "R5 super store hit");
      do_req(32'h0000_A010, 2'd3, 1'b0, 1'b1, "R6 reserved kind as load");
      do_req(32'h0008_A000, 2'd0, 1'b1, 1'b1, "R3 alias nomatch");
      do_req(32'h0000_A000, 2'd2, 1'b1, 1'b1, "R11 fetch sees only itlb");
      // R4: instruction entry present but invalid
      tlb_wr(1'b0, 1'b0, 5, (32'd5 << 13));
      tlb_wr(1'b0, 1'b1, 5, 32'h7700_0000 | 32'h08);
      do_req(32'h0000_A111, 2'd2, 1'b1, 1'b1, "R4 invalid entry");
      tlb_wr(1'b0, 1'b0, 5, (32'd5 << 13) | 32'd1);
      do_req(32'h0000_A111, 2'd2, 1'b1, 1'b1, "R6 super fetch hit");
      do_req(32'h0000_A111, 2'd2, 1'b0, 1'b1, "R6 user fetch denied");
      do_req(32'h0000_A222, 2'd0, 1'b1, 1'b1, "R11 data entry untouched");
      // R10: translation off
      do_req(32'hDEAD_BEEF, 2'd1, 1'b0, 1'b0, "R10 bypass store");
      do_req(32'h0008_A000, 2'd2, 1'b0, 1'b0, "R10 bypass fetch");

      // randomised mix
      for (int n = 0; n < 600; n++) begin
         if ($urandom % 10 < 3) begin
            int idx;
            logic [31:0] v;
            idx = int'($urandom % 64);
            if ($urandom % 2 == 0) begin
               v = {13'($urandom % 3), 6'(idx), 12'($urandom), 1'(($urandom % 4) != 0)};
               tlb_wr(1'($urandom), 1'b0, idx, v);
            end else begin
               tlb_wr(1'($urandom), 1'b1, idx, $urandom);
            end
         end else begin
            logic [31:0] va;
            va = {13'($urandom % 3), 6'($urandom % 64), 13'($urandom)};
            do_req(va, 2'($urandom), 1'($urandom), ($urandom % 8) != 0, "R3 R7 R8 random");
         end
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end
endmodule